// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when a temperature conversion runs and how long it takes. While enabled, it starts a conversion at the end of each period chosen by a rate code. While in shutdown, it stays idle until a one-shot request starts exactly one conversion. The length of a conversion depends only on the selected resolution, so the period and the conversion time are set independently. When a conversion ends, the raw sample from the converter model is truncated to the active resolution and stored in a result register, and a one-cycle valid strobe goes to the alarm logic downstream.

Configuration arrives as a single write strobe that carries a shutdown bit, a rate code and a resolution code together. If an enable write arrives while the block is already enabled, the rate falls back to one conversion per second whatever rate code comes with it. When the block enters shutdown, any periodic conversion in progress is abandoned and the alarm logic receives a one-cycle shutdown pulse. Time is counted only in ticks of a fixed timebase input. Each tick is nominally a quarter millisecond, so a 125 ms slot is 500 ticks and the basic conversion unit is 35 ticks.

Top module: `conv_sched`

## Requirements
- R1: After reset the block is enabled with the rate at one conversion per second (code 4) and the resolution at 12 bits (code 3). `busy_o`, `valid_o`, `os_done_o`, `shdn_pulse_o` and `result_o` are all zero.
- R2: While enabled, a conversion starts every P·2^k ticks, where P is `TICKS_PER_125MS`. Rate codes 0..6 give k = 9, 8, 7, 5, 3, 1, 0 (64 s, 32 s, 16 s, 4 s, 1 s, 250 ms, 125 ms), and code 7 behaves like code 6. The period counter restarts on every configuration write.
- R3: A conversion keeps `busy_o` high for exactly B·m ticks, where B is `CONV_BASE_TICKS`. Resolution codes 0, 1, 2, 3 (8, 9, 10, 12 bits) give m = 1, 2, 4, 16.
- R4: The stored result is `raw_i` as sampled in the finishing cycle, with its 4, 3, 2 or 0 least significant bits cleared for resolution code 0, 1, 2 or 3. The LSB always weighs 0.0625 °C.
- R5: `result_o` changes only at the clock edge where a conversion finishes. At that edge `busy_o` falls and `valid_o` goes high for exactly one cycle.
- R6: A period that expires while a conversion is still running is skipped, not queued.
- R7: A write with shutdown bit 0 while the block is already enabled sets the rate to code 4 (1 s), whatever `rate_i` carries. The resolution field is still taken.
- R8: Every other configuration write, whether it enters shutdown, stays in shutdown or leaves shutdown, stores `rate_i` as given.
- R9: A write that enters shutdown aborts a running conversion at that edge, without a valid strobe and without changing the result. It also raises `shdn_pulse_o` for exactly one cycle.
- R10: In shutdown, an accepted one-shot request runs one conversion. When that conversion finishes, `os_done_o` is set together with `valid_o`, and no further conversion follows. The flag clears on the next accepted one-shot or when the block leaves shutdown.
- R11: A one-shot request is ignored while the block is enabled or while a conversion is running.
- R12: The resolution is captured when a conversion starts. A resolution write during the conversion changes neither its length nor its truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| cfg_wr_i | input | 1 | Configuration write strobe |
| shdn_i | input | 1 | Shutdown bit carried by the write (1 = shutdown) |
| rate_i | input | 3 | Rate code carried by the write |
| res_i | input | 2 | Resolution code carried by the write |
| os_req_i | input | 1 | One-shot request |
| raw_i | input | DW | Raw converter sample, two's complement, 0.0625 °C LSB |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | DW | Last completed result |
| valid_o | output | 1 | One-cycle strobe: new result |
| os_done_o | output | 1 | One-shot conversion completed |
| shdn_pulse_o | output | 1 | One-cycle pulse on entering shutdown |

## Verification
Some properties are checked on every cycle: the valid strobe lasts one cycle and only ever follows a busy cycle, the result holds between strobes, the truncated bits of a fresh result are zero, both counters stay below their limits, an enable rewrite lands on the 1 s rate, and the shutdown pulse comes with an idle, quiet engine. Other behaviour shows up only in the bench's timed scenarios: the exact period for each rate code, the exact length for each resolution, how a period expiring during a long conversion is skipped, that one-shot requests are ignored, and that the resolution is latched at start.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

  typedef enum logic [2:0] {
    RATE_64S   = 3'd0,
    RATE_32S   = 3'd1,
    RATE_16S   = 3'd2,
    RATE_4S    = 3'd3,
    RATE_1S    = 3'd4,
    RATE_250MS = 3'd5,
    RATE_125MS = 3'd6,
    RATE_125MS_ALT = 3'd7
  } rate_e;

  typedef enum logic [1:0] {
    RES_8B  = 2'd0,
    RES_9B  = 2'd1,
    RES_10B = 2'd2,
    RES_12B = 2'd3
  } res_e;

  localparam rate_e RATE_DEFAULT = RATE_1S;
  localparam res_e  RES_DEFAULT  = RES_12B;

  // period = base slot << shift
  function automatic logic [3:0] rate_shift(rate_e r);
    case (r)
      RATE_64S:   return 4'd9;
      RATE_32S:   return 4'd8;
      RATE_16S:   return 4'd7;
      RATE_4S:    return 4'd5;
      RATE_1S:    return 4'd3;
      RATE_250MS: return 4'd1;
      default:    return 4'd0;
    endcase
  endfunction

  // conversion length = base unit << shift (doubling per bit, 12 bits = 16x)
  function automatic logic [2:0] res_shift(res_e r);
    case (r)
      RES_8B:  return 3'd0;
      RES_9B:  return 3'd1;
      RES_10B: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // number of fractional LSBs dropped at the given resolution
  function automatic logic [2:0] res_drop(res_e r);
    case (r)
      RES_8B:  return 3'd4;
      RES_9B:  return 3'd3;
      RES_10B: return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import conv_sched_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_wr_i,
  input  logic  shdn_i,
  input  rate_e rate_i,
  input  res_e  res_i,
  input  logic  os_req_i,
  input  logic  busy_i,
  input  logic  fin_i,
  output logic  shdn_o,
  output rate_e rate_o,
  output res_e  res_o,
  output logic  os_start_o,
  output logic  enter_o,
  output logic  shdn_pulse_o,
  output logic  os_done_o
);

  logic  shdn_q, shdn_d;
  rate_e rate_q, rate_d;
  res_e  res_q, res_d;
  logic  pulse_q, pulse_d;
  logic  os_act_q, os_act_d;
  logic  os_done_q, os_done_d;
  logic  enter, leave, rewrite, os_start;

  always_comb begin
    enter    = cfg_wr_i &&  shdn_i && !shdn_q;
    leave    = cfg_wr_i && !shdn_i &&  shdn_q;
    rewrite  = cfg_wr_i && !shdn_i && !shdn_q;
    os_start = os_req_i && shdn_q && !busy_i;

    shdn_d = shdn_q;
    rate_d = rate_q;
    res_d  = res_q;
    if (cfg_wr_i) begin
      shdn_d = shdn_i;
      res_d  = res_i;
      rate_d = rewrite ? RATE_DEFAULT : rate_i;
    end

    pulse_d = enter;

    os_act_d = os_act_q;
    if (os_start)
      os_act_d = 1'b1;
    else if (fin_i || enter)
      os_act_d = 1'b0;

    os_done_d = os_done_q;
    if (os_start || leave)
      os_done_d = 1'b0;
    else if (fin_i && os_act_q)
      os_done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shdn_q    <= 1'b0;
      rate_q    <= RATE_DEFAULT;
      res_q     <= RES_DEFAULT;
      pulse_q   <= 1'b0;
      os_act_q  <= 1'b0;
      os_done_q <= 1'b0;
    end else begin
      shdn_q    <= shdn_d;
      rate_q    <= rate_d;
      res_q     <= res_d;
      pulse_q   <= pulse_d;
      os_act_q  <= os_act_d;
      os_done_q <= os_done_d;
    end
  end

  assign shdn_o       = shdn_q;
  assign rate_o       = rate_q;
  assign res_o        = res_q;
  assign os_start_o   = os_start;
  assign enter_o      = enter;
  assign shdn_pulse_o = pulse_q;
  assign os_done_o    = os_done_q;

  p_rewrite_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && !shdn_i && !shdn_q) |=> (rate_q == RATE_DEFAULT));

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  p_pulse_in_shdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> shdn_q);

  p_done_needs_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(os_done_q) |-> $past(fin_i));

endmodule

// File: rtl/cs_period.sv
module cs_period
  import conv_sched_pkg::*;
#(
  parameter int unsigned TICKS_PER_125MS = 500
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  run_i,
  input  logic  clr_i,
  input  rate_e rate_i,
  output logic  expire_o
);

  localparam int unsigned MAX_TICKS = TICKS_PER_125MS * 512;
  localparam int PW = $clog2(MAX_TICKS + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] plen;
  logic          last;

  always_comb begin
    plen     = PW'(TICKS_PER_125MS) << rate_shift(rate_i);
    last     = (cnt_q == plen - PW'(1));
    expire_o = run_i && !clr_i && tick_i && last;

    cnt_d = cnt_q;
    if (clr_i || !run_i)
      cnt_d = '0;
    else if (tick_i)
      cnt_d = last ? '0 : cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < plen));

endmodule

// File: rtl/cs_conv.sv
module cs_conv
  import conv_sched_pkg::*;
#(
  parameter int unsigned CONV_BASE_TICKS = 35,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          abort_i,
  input  res_e          res_i,
  input  logic [DW-1:0] raw_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic          valid_o,
  output logic [DW-1:0] result_o
);

  localparam int LW = $clog2(CONV_BASE_TICKS * 16 + 1);

  logic          busy_q, busy_d;
  logic [LW-1:0] cnt_q, cnt_d;
  res_e          rlat_q, rlat_d;
  logic          valid_q, valid_d;
  logic [DW-1:0] res_q, res_d;
  logic [LW-1:0] len;
  logic [DW-1:0] drop_mask;
  logic          fin;

  always_comb begin
    len       = LW'(CONV_BASE_TICKS) << res_shift(rlat_q);
    drop_mask = (DW'(1) << res_drop(rlat_q)) - DW'(1);
    fin       = busy_q && tick_i && !abort_i && (cnt_q == len - LW'(1));

    busy_d  = busy_q;
    cnt_d   = cnt_q;
    rlat_d  = rlat_q;
    res_d   = res_q;
    valid_d = 1'b0;

    if (abort_i) begin
      busy_d = 1'b0;
    end else if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      rlat_d = res_i;
    end else if (fin) begin
      busy_d  = 1'b0;
      valid_d = 1'b1;
      res_d   = raw_i & ~drop_mask;
    end else if (busy_q && tick_i) begin
      cnt_d = cnt_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      rlat_q  <= RES_DEFAULT;
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      rlat_q  <= rlat_d;
      valid_q <= valid_d;
      res_q   <= res_d;
    end
  end

  assign busy_o   = busy_q;
  assign fin_o    = fin;
  assign valid_o  = valid_q;
  assign result_o = res_q;

  p_cnt_below_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len));

  p_valid_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  p_valid_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (!busy_q && $past(busy_q)));

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(res_q));

  p_low_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (((res_q >> res_drop(rlat_q)) << res_drop(rlat_q)) == res_q));

  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_q && !valid_q));

endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int unsigned TICKS_PER_125MS = 500,
  parameter int unsigned CONV_BASE_TICKS = 35,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cfg_wr_i,
  input  logic          shdn_i,
  input  logic [2:0]    rate_i,
  input  logic [1:0]    res_i,
  input  logic          os_req_i,
  input  logic [DW-1:0] raw_i,
  output logic          busy_o,
  output logic [DW-1:0] result_o,
  output logic          valid_o,
  output logic          os_done_o,
  output logic          shdn_pulse_o
);

  logic  shdn, os_start, enter, expire, fin, busy;
  rate_e rate_cur;
  res_e  res_cur;

  cs_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_i     (cfg_wr_i),
    .shdn_i       (shdn_i),
    .rate_i       (rate_e'(rate_i)),
    .res_i        (res_e'(res_i)),
    .os_req_i     (os_req_i),
    .busy_i       (busy),
    .fin_i        (fin),
    .shdn_o       (shdn),
    .rate_o       (rate_cur),
    .res_o        (res_cur),
    .os_start_o   (os_start),
    .enter_o      (enter),
    .shdn_pulse_o (shdn_pulse_o),
    .os_done_o    (os_done_o)
  );

  cs_period #(.TICKS_PER_125MS(TICKS_PER_125MS)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .run_i    (!shdn),
    .clr_i    (cfg_wr_i),
    .rate_i   (rate_cur),
    .expire_o (expire)
  );

  cs_conv #(.CONV_BASE_TICKS(CONV_BASE_TICKS), .DW(DW)) u_conv (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .start_i  (expire || os_start),
    .abort_i  (enter),
    .res_i    (res_cur),
    .raw_i    (raw_i),
    .busy_o   (busy),
    .fin_o    (fin),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  assign busy_o = busy;

  p_pulse_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_pulse_o |-> (!busy_o && !valid_o));

  p_done_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(os_done_o) |-> valid_o);

endmodule

// File: tb/conv_sched_test.sv
`timescale 1ns/1ps
module conv_sched_test;

  localparam int P  = 8;
  localparam int B  = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b1;
  logic          cfg_wr_i = 1'b0;
  logic          shdn_i = 1'b0;
  logic [2:0]    rate_i = 3'd0;
  logic [1:0]    res_i = 2'd0;
  logic          os_req_i = 1'b0;
  logic [DW-1:0] raw_i = 16'hFE7F;
  logic          busy_o, valid_o, os_done_o, shdn_pulse_o;
  logic [DW-1:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int rise_t = 0, prev_rise_t = 0, rise_cnt = 0;
  int valid_t = 0, valid_cnt = 0;
  logic busy_prev = 1'b0;
  bit done = 0;

  conv_sched #(.TICKS_PER_125MS(P), .CONV_BASE_TICKS(B), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_wr_i(cfg_wr_i),
    .shdn_i(shdn_i), .rate_i(rate_i), .res_i(res_i), .os_req_i(os_req_i),
    .raw_i(raw_i), .busy_o(busy_o), .result_o(result_o), .valid_o(valid_o),
    .os_done_o(os_done_o), .shdn_pulse_o(shdn_pulse_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (busy_o && !busy_prev) begin
      prev_rise_t = rise_t;
      rise_t = cyc;
      rise_cnt++;
    end
    if (valid_o) begin
      valid_t = cyc;
      valid_cnt++;
    end
    busy_prev = busy_o;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr_i = 1'b0; os_req_i = 1'b0; shdn_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input logic s, input logic [2:0] r, input logic [1:0] q);
    @(negedge clk);
    cfg_wr_i = 1'b1; shdn_i = s; rate_i = r; res_i = q;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic os_pulse();
    @(negedge clk); os_req_i = 1'b1;
    @(negedge clk); os_req_i = 1'b0;
  endtask

  function automatic int exp_mask(int r);
    int d;
    d = (r == 0) ? 4 : (r == 1) ? 3 : (r == 2) ? 2 : 0;
    return int'(raw_i) & ~((1 << d) - 1);
  endfunction

  task automatic t_reset_defaults();
    int k;
    do_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 valid", valid_o, 0);
    chk("R1 result", result_o, 0);
    chk("R1 os_done", os_done_o, 0);
    chk("R1 shdn_pulse", shdn_pulse_o, 0);
    k = rise_cnt;
    wait (rise_cnt == k + 2);
    chk("R1 default 1 s period", rise_t - prev_rise_t, 8 * P);
    k = valid_cnt;
    wait (valid_cnt == k + 1);
    chk("R1 default 12-bit length", valid_t - rise_t, 16 * B);
  endtask

  task automatic t_periods();
    int codes[5] = '{6, 5, 4, 3, 0};
    int exps[5]  = '{1, 2, 8, 32, 512};
    do_reset();
    for (int i = 0; i < 5; i++) begin
      int k;
      cfg(1'b1, 3'(codes[i]), 2'd0);
      cfg(1'b0, 3'(codes[i]), 2'd0);
      k = rise_cnt;
      wait (rise_cnt == k + 2);
      chk($sformatf("R2 period code %0d", codes[i]), rise_t - prev_rise_t, exps[i] * P);
    end
  endtask

  task automatic t_conv_lengths();
    int lens[4] = '{1, 2, 4, 16};
    do_reset();
    for (int r = 0; r < 4; r++) begin
      int k;
      cfg(1'b1, 3'd4, 2'(r));
      k = valid_cnt;
      os_pulse();
      wait (valid_cnt == k + 1);
      chk($sformatf("R3 length res %0d", r), valid_t - rise_t, lens[r] * B);
      chk($sformatf("R4 truncation res %0d", r), result_o, exp_mask(r));
      chk($sformatf("R10 os_done res %0d", r), os_done_o, 1);
      chk("R5 busy falls with valid", busy_o, 0);
      @(negedge clk);
      chk("R5 valid one cycle", valid_o, 0);
    end
  endtask

  task automatic t_skip();
    int k;
    do_reset();
    cfg(1'b1, 3'd6, 2'd3);
    cfg(1'b0, 3'd6, 2'd3);
    k = rise_cnt;
    wait (rise_cnt == k + 2);
    chk("R6 skipped period interval", rise_t - prev_rise_t, 56);
  endtask

  task automatic t_enable_rewrite();
    int k;
    do_reset();
    cfg(1'b1, 3'd6, 2'd0);
    cfg(1'b0, 3'd6, 2'd0);
    k = rise_cnt;
    wait (rise_cnt == k + 2);
    chk("R8 wake stores rate", rise_t - prev_rise_t, P);
    cfg(1'b0, 3'd6, 2'd0);
    k = rise_cnt;
    wait (rise_cnt == k + 2);
    chk("R7 rewrite forces 1 s", rise_t - prev_rise_t, 8 * P);
  endtask

  task automatic t_abort();
    int k, v;
    do_reset();
    k = rise_cnt;
    wait (rise_cnt == k + 1);
    repeat (10) @(negedge clk);
    v = valid_cnt;
    cfg(1'b1, 3'd4, 2'd3);
    chk("R9 busy dropped", busy_o, 0);
    chk("R9 shutdown pulse", shdn_pulse_o, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", shdn_pulse_o, 0);
    repeat (100) @(negedge clk);
    chk("R9 no valid after abort", valid_cnt, v);
    chk("R9 result unchanged", result_o, 0);
  endtask

  task automatic t_oneshot_ignored();
    int k, v;
    do_reset();
    k = rise_cnt;
    os_pulse();
    chk("R11 ignored while enabled", busy_o, 0);
    repeat (5) @(negedge clk);
    chk("R11 no start while enabled", rise_cnt, k);
    cfg(1'b1, 3'd4, 2'd3);
    v = valid_cnt;
    os_pulse();
    repeat (10) @(negedge clk);
    os_pulse();
    wait (valid_cnt == v + 1);
    chk("R11 ignored while busy", valid_t - rise_t, 16 * B);
    repeat (100) @(negedge clk);
    chk("R10 single conversion", valid_cnt, v + 1);
    chk("R10 idle afterwards", busy_o, 0);
    cfg(1'b0, 3'd4, 2'd3);
    chk("R10 os_done cleared on wake", os_done_o, 0);
  endtask

  task automatic t_res_latched();
    int v;
    do_reset();
    cfg(1'b1, 3'd4, 2'd3);
    v = valid_cnt;
    os_pulse();
    repeat (5) @(negedge clk);
    cfg(1'b1, 3'd4, 2'd0);
    wait (valid_cnt == v + 1);
    chk("R12 length latched", valid_t - rise_t, 16 * B);
    chk("R12 truncation latched", result_o, exp_mask(3));
  endtask

  initial begin
    t_reset_defaults();
    t_periods();
    t_conv_lengths();
    t_skip();
    t_enable_rewrite();
    t_abort();
    t_oneshot_ignored();
    t_res_latched();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule